// File: doc/BRIEF.md
# Core Test Mode Decoder and Scan Chain Configurator

This block sits beside one core and turns a 3-bit test-mode selection into everything that core's test logic needs. It produces the mode code for the boundary wrapper cells, the routing selects that join short internal chain segments into the chain topology of the chosen mode, and registered scan-enable and test-clock enables. The five configurations are mission (functional), compressed scan, narrow uncompressed scan, wide uncompressed scan and outward test. Outward test shifts only the wrapper segments and freezes everything inside the core.

The core's scan storage is modelled as `NSEG` segments of `SEG_LEN` flops each. The last `NWRP` segments are wrapper segments and the rest are core-internal. The lower half of the segments belongs to test clock domain A and the upper half to domain B. In compressed mode each segment is one channel of an external compressor. In wide mode each segment is one top-level chain. In narrow mode the segments of each domain are interleaved into `NARROW` chains, and no chain ever crosses a domain. In outward mode the wrapper segments form one chain. In mission mode no scan output toggles and no storage moves.

Top module: `scan_mode_cfg`

## Requirements
- R1: `mode_sel` codes are 0 mission, 1 compressed, 2 narrow, 3 wide and 4 outward. Codes 5, 6 and 7 act exactly like mission.
- R2: `mode_sel` is sampled at every rising clock edge while `rst_n` is high, and the new configuration appears only after that edge. While `rst_n` is low, the block is held in mission at once, whatever `mode_sel` is.
- R3: `wrp_mode` is 0 (off) in mission, 1 (inward test) in the compressed, narrow and wide modes, and 2 (outward test) in outward mode.
- R4: In mission, every enable output is 0, `link_sel` is all zero, and `scan_out` and `cmp_so` are all zero. No segment changes, even with `scan_en` high.
- R5: In compressed mode, segment i is a `SEG_LEN`-bit chain from `cmp_si[i]` to `cmp_so[i]`, and `scan_out` is all zero. `scan_in` is ignored.
- R6: In wide mode, segment i is a `SEG_LEN`-bit chain from `scan_in[i]` to `scan_out[i]` for every i below `NSEG` (default 90 pairs). `cmp_so` is zero.
- R7: In narrow mode there are `NARROW` chains (default 17) on pins 0 to `NARROW`-1. Segment i with local index j inside its domain joins chain base+(j mod n). Domain A has base 0 and n=`NARROW`/2. Domain B has base `NARROW`/2 and n=`NARROW`-`NARROW`/2. Segments of a chain follow in ascending index from scan-in to scan-out, and pins at or above `NARROW` read 0.
- R8: Segments 0 to `NSEG`/2-1 (domain A) appear only on narrow chains below `NARROW`/2. All other segments appear only on the narrow chains above that range. Chain lengths follow from this split (default: chains 0-4 are 12 bits long, the others 10 bits).
- R9: The wrapper segments, indices `NSEG`-`NWRP` and up, are ordinary members of the compressed, wide and narrow topologies.
- R10: In outward mode the wrapper segments form one chain of `NWRP`*`SEG_LEN` bits from `scan_in[0]` to `scan_out[0]`, in ascending order. `int_se_en` and both `int_ck_en` bits are 0, and internal segments keep their contents. All other outputs of the scan buses are 0.
- R11: The enables `int_se_en`, `int_ck_en` (both bits), `wrp_se_en` and `wrp_ck_en` are register outputs. They are 1 in the compressed, narrow and wide modes. A segment shifts only at an edge where `scan_en` is high and its enables are set; with `scan_en` low every segment holds.
- R12: The field `link_sel[2i+1:2i]` gives the data source of segment i: 0 none, 1 its compressor channel, 2 a scan-in pin, 3 the preceding segment of its chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low test reset, asynchronous |
| mode_sel | input | 3 | Test-mode selection code |
| scan_en | input | 1 | Shift request from the tester |
| scan_in | input | NSEG | Top-level scan-in pins |
| cmp_si | input | NSEG | Channel inputs from the decompressor |
| scan_out | output | NSEG | Top-level scan-out pins |
| cmp_so | output | NSEG | Channel outputs to the compactor |
| wrp_mode | output | 2 | Wrapper-cell mode code |
| int_se_en | output | 1 | Scan-enable gate for internal segments |
| int_ck_en | output | 2 | Test-clock gates for internal segments, one per domain |
| wrp_se_en | output | 1 | Scan-enable gate for wrapper segments |
| wrp_ck_en | output | 1 | Test-clock gate for wrapper segments |
| link_sel | output | 2*NSEG | Per-segment source select codes |

## Verification
Each configuration is first driven with a lone 1 followed by zeros. The cycle in which that bit reaches each scan-out shows the chain length, so a wrong segment count or a chain crossing domains in narrow mode stands out. Random data then checks order and routing on every lane, including the unused bus, which carries random data that must be ignored. An alternating pattern shows up swapped or shorted neighbouring lanes. Wide-mode contents are loaded before the mission, outward and scan-enable-low phases and read back afterwards, which shows that gated segments really held their data.

// File: rtl/scan_cfg_pkg.sv
package scan_cfg_pkg;

  typedef enum logic [2:0] {
    M_MISSION = 3'd0,
    M_COMP    = 3'd1,
    M_NARROW  = 3'd2,
    M_WIDE    = 3'd3,
    M_OUTWARD = 3'd4
  } tmode_e;

  typedef enum logic [1:0] {
    W_OFF     = 2'd0,
    W_INWARD  = 2'd1,
    W_OUTWARD = 2'd2
  } wmode_e;

  localparam logic [1:0] L_NONE = 2'd0;
  localparam logic [1:0] L_CHAN = 2'd1;
  localparam logic [1:0] L_PIN  = 2'd2;
  localparam logic [1:0] L_PRED = 2'd3;

  function automatic tmode_e decode_sel(input logic [2:0] s);
    case (s)
      3'd1:    return M_COMP;
      3'd2:    return M_NARROW;
      3'd3:    return M_WIDE;
      3'd4:    return M_OUTWARD;
      default: return M_MISSION;
    endcase
  endfunction

  // domain of a segment: lower half A (0), upper half B (1)
  function automatic int dom_of(input int i, input int nseg);
    return (i < nseg / 2) ? 0 : 1;
  endfunction

  function automatic int dom_first(input int d, input int nseg);
    return (d == 0) ? 0 : nseg / 2;
  endfunction

  function automatic int dom_size(input int d, input int nseg);
    return (d == 0) ? nseg / 2 : nseg - nseg / 2;
  endfunction

  function automatic int dom_chains(input int d, input int nar);
    return (d == 0) ? nar / 2 : nar - nar / 2;
  endfunction

  function automatic int dom_base(input int d, input int nar);
    return (d == 0) ? 0 : nar / 2;
  endfunction

  function automatic int nar_chain(input int i, input int nseg, input int nar);
    int d;
    d = dom_of(i, nseg);
    return dom_base(d, nar) + (i - dom_first(d, nseg)) % dom_chains(d, nar);
  endfunction

  function automatic bit nar_head(input int i, input int nseg, input int nar);
    int d;
    d = dom_of(i, nseg);
    return (i - dom_first(d, nseg)) < dom_chains(d, nar);
  endfunction

  function automatic int nar_pred(input int i, input int nseg, input int nar);
    if (nar_head(i, nseg, nar)) return i;
    return i - dom_chains(dom_of(i, nseg), nar);
  endfunction

  // last segment of narrow chain c
  function automatic int nar_tail(input int c, input int nseg, input int nar);
    int d, k, s, n;
    d = (c < nar / 2) ? 0 : 1;
    k = c - dom_base(d, nar);
    s = dom_size(d, nseg);
    n = dom_chains(d, nar);
    return dom_first(d, nseg) + k + n * ((s - 1 - k) / n);
  endfunction

endpackage

// File: rtl/scm_ctrl.sv
module scm_ctrl
  import scan_cfg_pkg::*;
#(
  parameter int NSEG   = 90,
  parameter int NARROW = 17,
  parameter int NWRP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  output tmode_e            mode_q,
  output wmode_e            wrp_mode,
  output logic              int_se_en,
  output logic [1:0]        int_ck_en,
  output logic              wrp_se_en,
  output logic              wrp_ck_en,
  output logic [2*NSEG-1:0] link_sel
);

  localparam int FIRST_WRP = NSEG - NWRP;

  tmode_e            mode_d;
  wmode_e            wm_d;
  logic              ise_d, wse_d, wck_d;
  logic [1:0]        ick_d;
  logic [2*NSEG-1:0] links_d;

  always_comb begin
    mode_d = decode_sel(mode_sel);
    wm_d   = W_OFF;
    ise_d  = 1'b0;
    ick_d  = 2'b00;
    wse_d  = 1'b0;
    wck_d  = 1'b0;
    case (mode_d)
      M_COMP, M_NARROW, M_WIDE: begin
        wm_d  = W_INWARD;
        ise_d = 1'b1;
        ick_d = 2'b11;
        wse_d = 1'b1;
        wck_d = 1'b1;
      end
      M_OUTWARD: begin
        wm_d  = W_OUTWARD;
        wse_d = 1'b1;
        wck_d = 1'b1;
      end
      default: ;
    endcase
    for (int i = 0; i < NSEG; i++) begin
      case (mode_d)
        M_COMP:   links_d[2*i +: 2] = L_CHAN;
        M_WIDE:   links_d[2*i +: 2] = L_PIN;
        M_NARROW: links_d[2*i +: 2] = nar_head(i, NSEG, NARROW) ? L_PIN : L_PRED;
        M_OUTWARD: begin
          if (i == FIRST_WRP)     links_d[2*i +: 2] = L_PIN;
          else if (i > FIRST_WRP) links_d[2*i +: 2] = L_PRED;
          else                    links_d[2*i +: 2] = L_NONE;
        end
        default:  links_d[2*i +: 2] = L_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_MISSION;
      wrp_mode  <= W_OFF;
      int_se_en <= 1'b0;
      int_ck_en <= 2'b00;
      wrp_se_en <= 1'b0;
      wrp_ck_en <= 1'b0;
      link_sel  <= '0;
    end else begin
      mode_q    <= mode_d;
      wrp_mode  <= wm_d;
      int_se_en <= ise_d;
      int_ck_en <= ick_d;
      wrp_se_en <= wse_d;
      wrp_ck_en <= wck_d;
      link_sel  <= links_d;
    end
  end

  // R1
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel > 3'd4) |=> (mode_q == M_MISSION));

  // R3
  wrapper_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_mode == W_INWARD) |-> (mode_q inside {M_COMP, M_NARROW, M_WIDE}));

  // R10
  outward_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OUTWARD) |-> (!int_se_en && int_ck_en == 2'b00 && wrp_se_en && wrp_ck_en));

  // R4
  mission_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_MISSION) |-> (wrp_mode == W_OFF && !int_se_en && int_ck_en == 2'b00
                               && !wrp_se_en && !wrp_ck_en && link_sel == '0));

endmodule

// File: rtl/scm_route.sv
module scm_route
  import scan_cfg_pkg::*;
#(
  parameter int NSEG   = 90,
  parameter int NARROW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode_q,
  input  logic [2*NSEG-1:0] link_sel,
  input  logic [NSEG-1:0]   scan_in,
  input  logic [NSEG-1:0]   cmp_si,
  input  logic [NSEG-1:0]   tails,
  output logic [NSEG-1:0]   seg_in,
  output logic [NSEG-1:0]   scan_out,
  output logic [NSEG-1:0]   cmp_so
);

  for (genvar i = 0; i < NSEG; i++) begin : g_in
    localparam int PIN_N  = nar_chain(i, NSEG, NARROW);
    localparam int PRED_N = nar_pred(i, NSEG, NARROW);
    localparam int PRED_O = (i > 0) ? i - 1 : 0;
    always_comb begin
      case (link_sel[2*i +: 2])
        L_CHAN: seg_in[i] = cmp_si[i];
        L_PIN: begin
          if (mode_q == M_NARROW)       seg_in[i] = scan_in[PIN_N];
          else if (mode_q == M_OUTWARD) seg_in[i] = scan_in[0];
          else                          seg_in[i] = scan_in[i];
        end
        L_PRED:  seg_in[i] = (mode_q == M_OUTWARD) ? tails[PRED_O] : tails[PRED_N];
        default: seg_in[i] = 1'b0;
      endcase
    end
  end

  for (genvar p = 0; p < NSEG; p++) begin : g_out
    localparam int TAIL_N = (p < NARROW) ? nar_tail(p, NSEG, NARROW) : 0;
    always_comb begin
      case (mode_q)
        M_WIDE:    scan_out[p] = tails[p];
        M_NARROW:  scan_out[p] = (p < NARROW) ? tails[TAIL_N] : 1'b0;
        M_OUTWARD: scan_out[p] = (p == 0) ? tails[NSEG-1] : 1'b0;
        default:   scan_out[p] = 1'b0;
      endcase
    end
  end

  assign cmp_so = (mode_q == M_COMP) ? tails : '0;

  // R4
  mission_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_MISSION) |-> (scan_out == '0 && cmp_so == '0));

  // R5
  comp_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_COMP) |-> (scan_out == '0));

endmodule

// File: rtl/scm_seg.sv
module scm_seg #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic si,
  output logic so
);

  logic [LEN-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift) begin
      for (int k = 0; k < LEN; k++) begin
        q[k] <= (k == 0) ? si : q[(k == 0) ? 0 : k-1];
      end
    end
  end

  assign so = q[LEN-1];

endmodule

// File: rtl/scan_mode_cfg.sv
module scan_mode_cfg
  import scan_cfg_pkg::*;
#(
  parameter int NSEG    = 90,
  parameter int NARROW  = 17,
  parameter int NWRP    = 2,
  parameter int SEG_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              scan_en,
  input  logic [NSEG-1:0]   scan_in,
  input  logic [NSEG-1:0]   cmp_si,
  output logic [NSEG-1:0]   scan_out,
  output logic [NSEG-1:0]   cmp_so,
  output logic [1:0]        wrp_mode,
  output logic              int_se_en,
  output logic [1:0]        int_ck_en,
  output logic              wrp_se_en,
  output logic              wrp_ck_en,
  output logic [2*NSEG-1:0] link_sel
);

  localparam int NINT = NSEG - NWRP;

  tmode_e          mode_q;
  wmode_e          wm_q;
  logic [NSEG-1:0] tails, seg_in, shift_vec;
  logic [NINT-1:0] int_tails;

  scm_ctrl #(.NSEG(NSEG), .NARROW(NARROW), .NWRP(NWRP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_q(mode_q),
    .wrp_mode(wm_q), .int_se_en(int_se_en), .int_ck_en(int_ck_en),
    .wrp_se_en(wrp_se_en), .wrp_ck_en(wrp_ck_en), .link_sel(link_sel)
  );

  assign wrp_mode = wm_q;

  scm_route #(.NSEG(NSEG), .NARROW(NARROW)) u_route (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .link_sel(link_sel),
    .scan_in(scan_in), .cmp_si(cmp_si), .tails(tails),
    .seg_in(seg_in), .scan_out(scan_out), .cmp_so(cmp_so)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    if (i >= NINT) begin : g_wrp
      assign shift_vec[i] = scan_en & wrp_se_en & wrp_ck_en;
    end else begin : g_int
      localparam int DOM = dom_of(i, NSEG);
      assign shift_vec[i] = scan_en & int_se_en & int_ck_en[DOM];
    end
    scm_seg #(.LEN(SEG_LEN)) u_seg (
      .clk(clk), .rst_n(rst_n), .shift(shift_vec[i]), .si(seg_in[i]), .so(tails[i])
    );
  end

  assign int_tails = tails[NINT-1:0];

  // R10
  outward_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OUTWARD) |=> $stable(int_tails));

  // R4
  mission_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_MISSION) |=> $stable(tails));

  // R11
  se_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en) |=> $stable(tails));

endmodule

// File: tb/sim_scan_mode_cfg.sv
module sim_scan_mode_cfg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NSEG = 90, NARROW = 17, NWRP = 2, SEG_LEN = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode_sel = 3'd3;
  logic              scan_en = 1'b0;
  logic [NSEG-1:0]   scan_in = '0, cmp_si = '0;
  logic [NSEG-1:0]   scan_out, cmp_so;
  logic [1:0]        wrp_mode, int_ck_en;
  logic              int_se_en, wrp_se_en, wrp_ck_en;
  logic [2*NSEG-1:0] link_sel;

  int checks = 0, errors = 0;
  int cur_mode = 0;
  bit use_cmp = 0;
  int lane_len [NSEG];
  int q     [NSEG][$];
  int wsave [NSEG][$];

  always #2.5 clk = ~clk;

  scan_mode_cfg #(.NSEG(NSEG), .NARROW(NARROW), .NWRP(NWRP), .SEG_LEN(SEG_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .scan_en(scan_en),
    .scan_in(scan_in), .cmp_si(cmp_si), .scan_out(scan_out), .cmp_so(cmp_so),
    .wrp_mode(wrp_mode), .int_se_en(int_se_en), .int_ck_en(int_ck_en),
    .wrp_se_en(wrp_se_en), .wrp_ck_en(wrp_ck_en), .link_sel(link_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lk(input int i);
    return int'(link_sel[2*i +: 2]);
  endfunction

  task automatic chk_ctrl(input int m, input string tag);
    int wm, en;
    wm = (m == 0) ? 0 : (m == 4) ? 2 : 1;
    en = (m >= 1 && m <= 3) ? 1 : 0;
    chk(wrp_mode == wm, {tag, " wrp_mode"}, wrp_mode, wm);
    chk(int_se_en == en && int_ck_en == (en ? 2'b11 : 2'b00),
        {tag, " R11 internal enables"}, {int_se_en, int_ck_en}, en ? 7 : 0);
    chk(wrp_se_en == (m != 0) && wrp_ck_en == (m != 0),
        {tag, " R11 wrapper enables"}, {wrp_se_en, wrp_ck_en}, (m != 0) ? 3 : 0);
  endtask

  task automatic set_lanes(input int m);
    int cnt [NSEG];
    for (int l = 0; l < NSEG; l++) cnt[l] = 0;
    use_cmp = (m == 1);
    if (m == 1 || m == 3) for (int l = 0; l < NSEG; l++) cnt[l] = 1;
    if (m == 4) cnt[0] = NWRP;
    if (m == 2) begin
      for (int j = 0; j < NSEG / 2; j++) cnt[j % (NARROW / 2)]++;
      for (int j = 0; j < NSEG - NSEG / 2; j++)
        cnt[NARROW / 2 + j % (NARROW - NARROW / 2)]++;
    end
    for (int l = 0; l < NSEG; l++) begin
      lane_len[l] = cnt[l] * SEG_LEN;
      q[l].delete();
      for (int k = 0; k < lane_len[l]; k++) q[l].push_back(-1);
    end
  endtask

  task automatic set_mode(input logic [2:0] sel, input bit keep);
    int prev, nm, pwm;
    scan_en = 1'b0;
    prev = cur_mode;
    if (prev == 3) for (int l = 0; l < NSEG; l++) wsave[l] = q[l];
    mode_sel = sel;
    #1;
    pwm = (prev == 0) ? 0 : (prev == 4) ? 2 : 1;
    chk(wrp_mode == pwm, "R2 mode held before edge", wrp_mode, pwm);
    @(posedge clk); @(negedge clk);
    nm = (sel <= 3'd4) ? int'(sel) : 0;
    cur_mode = nm;
    chk_ctrl(nm, (sel > 3'd4) ? "R1 unused code" : "R3");
    case (nm)
      0: chk(link_sel == '0, "R12 mission links", lk(0), 0);
      1: chk(lk(0) == 1 && lk(NSEG-1) == 1, "R12 compressed links", lk(0), 1);
      2: begin
        chk(lk(0) == 2 && lk(NSEG/2) == 2, "R12 narrow heads", lk(NSEG/2), 2);
        chk(lk(NARROW/2) == 3 && lk(NSEG/2 + NARROW - NARROW/2) == 3,
            "R12 narrow predecessors", lk(NARROW/2), 3);
      end
      3: chk(lk(0) == 2 && lk(NSEG-1) == 2, "R12 wide links", lk(0), 2);
      default: chk(lk(NSEG-NWRP) == 2 && lk(NSEG-1) == 3 && lk(0) == 0,
                   "R12 outward links", lk(NSEG-1), 3);
    endcase
    set_lanes(nm);
    if (keep && nm == 3) begin
      for (int l = 0; l < NSEG; l++) q[l] = wsave[l];
      if (prev == 4)
        for (int l = NSEG - NWRP; l < NSEG; l++)
          for (int k = 0; k < SEG_LEN; k++) q[l][k] = -1;
    end
  endtask

  // pat 0 random, 1 alternating, 2 lone one then zeros
  task automatic step(input bit se, input int pat, input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      logic [NSEG-1:0] act, other, v, junk;
      int bad, eb, ab, e;
      bad = -1; eb = 0; ab = 0;
      act   = use_cmp ? cmp_so : scan_out;
      other = use_cmp ? scan_out : cmp_so;
      checks++;
      for (int l = 0; l < NSEG; l++) begin
        e = (lane_len[l] == 0) ? 0 : q[l][$];
        if (e >= 0 && int'(act[l]) != e && bad < 0) begin
          bad = l; eb = e; ab = int'(act[l]);
        end
      end
      if (bad < 0 && other != '0) begin
        bad = NSEG; eb = 0; ab = 1;
      end
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s lane %0d cycle %0d actual=%0d expected=%0d", tag, bad, c, ab, eb);
      end
      for (int l = 0; l < NSEG; l++) begin
        v[l]    = (pat == 0) ? 1'($urandom % 2) : (pat == 1) ? 1'((c + l) % 2) : 1'(c == 0);
        junk[l] = 1'($urandom % 2);
      end
      if (use_cmp) begin cmp_si = v; scan_in = junk; end
      else begin scan_in = v; cmp_si = junk; end
      scan_en = se;
      if (se)
        for (int l = 0; l < NSEG; l++)
          if (lane_len[l] > 0) begin
            void'(q[l].pop_back());
            q[l].push_front(int'(v[l]));
          end
      @(posedge clk); @(negedge clk);
    end
    scan_en = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    set_lanes(0);
    repeat (3) @(negedge clk);
    chk_ctrl(0, "R2 reset ignores mode_sel");
    chk(scan_out == '0 && cmp_so == '0, "R4 reset outputs", int'(scan_out[0]), 0);
    mode_sel = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ctrl(0, "R4 mission after reset");

    // wide
    set_mode(3'd3, 0);
    step(1, 2, 6, "R6 wide impulse");
    step(1, 0, 8, "R6 wide random");
    step(1, 1, 6, "R6 R9 wide alternating");
    step(0, 0, 4, "R11 scan_en low hold");
    step(1, 0, 3, "R11 shift resumes");

    // mission freezes storage
    set_mode(3'd0, 0);
    step(1, 0, 6, "R4 mission quiet");
    set_mode(3'd3, 1);
    step(1, 0, 4, "R4 contents kept through mission");

    // outward
    set_mode(3'd4, 0);
    step(1, 2, 8, "R10 outward impulse");
    step(1, 0, 16, "R10 outward random");
    set_mode(3'd3, 1);
    step(1, 0, 4, "R10 internal contents held");

    // narrow
    set_mode(3'd2, 0);
    step(1, 2, 16, "R7 R8 narrow impulse");
    step(1, 0, 30, "R7 R9 narrow random");
    step(1, 1, 16, "R8 narrow alternating");

    // compressed
    set_mode(3'd1, 0);
    step(1, 2, 5, "R5 compressed impulse");
    step(1, 0, 10, "R5 R9 compressed random");

    // unused codes
    set_mode(3'd6, 0);
    step(1, 0, 4, "R1 unused code quiet");
    set_mode(3'd7, 0);
    set_mode(3'd5, 0);

    // asynchronous reset in wide mode
    set_mode(3'd3, 0);
    step(1, 0, 4, "R6 before reset");
    rst_n = 1'b0;
    #1;
    chk(wrp_mode == 2'd0 && !int_se_en && !wrp_se_en, "R2 async reset",
        {wrp_mode, int_se_en, wrp_se_en}, 0);
    chk(scan_out == '0, "R2 R4 outputs in reset", int'(scan_out != '0), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_mode = 0;
    set_mode(3'd3, 0);
    step(1, 0, 6, "R6 after reset");

    summary();
    $finish;
  end

endmodule